// File: doc/BRIEF.md
# Predicated Vector Element Issue Sequencer

This block turns one decoded vector operation into a stream of element operations. An operation names a destination register and two source registers, each with its own vector length. Element `e` of a vector operand lives in register `base + e`. A source of length 1 is a scalar and is broadcast to every element. The sequencer issues up to `LANES` elements per cycle. It walks a vector of `VL` elements in `ceil(VL / LANES)` back-to-back passes, and lanes with no element left in the last pass stay idle. The same block serves a single sequential ALU lane (`LANES = 1`) or a wider group of lanes, and software sees the same behaviour in both cases.

Predication is bound to the destination register, not encoded in the operation. A small binding table maps a destination register number to a predicate register. When an operation is accepted, the block looks up its destination, presents the predicate register number on `pred_sel`, and captures the value returned on `pred_value`. Bit `e` of that value gates the writeback of element `e`. An element that is masked off is still walked, but its write enable stays low, so the old register contents survive. A masked-off element is never written with zero. If the destination has no binding, every element writes back.

Illegal operand shapes are rejected when the operation is presented. The block then raises a one-cycle exception pulse and issues no element and no writeback.

Top module: `pred_elem_sequencer`

## Requirements
- R1: An operation is accepted on a rising edge where `op_valid` is 1 and `busy` is 0. `busy` is 0 after reset. For a legal operation, `busy` is then high for exactly `ceil(VL/LANES)` cycles, starting with the cycle after acceptance. `VL` is `len_dst`.
- R2: In pass `p`, lane `l` carries element `e = p*LANES + l`. `lane_issue[l]` is 1 exactly when `busy` is 1 and `e < VL`, and then `lane_dst` holds `op_dst + e`. Lanes past the last element idle, and all lanes are 0 while `busy` is 0.
- R3: For each source, a length above 1 gives lane register `base + e`. A length of exactly 1 gives `base` on every lane (scalar broadcast).
- R4: If binding entry `i` has its valid bit set and its destination field equals `op_dst`, then `lane_wen[l] = lane_issue[l] & pred_value[e]`, with `pred_value` captured at acceptance. A 0 bit leaves `lane_wen` low for that element and never writes zero.
- R5: If no valid binding entry matches `op_dst`, every issued element has `lane_wen` set. Entries whose valid bit is 0 are never matched.
- R6: While `op_valid` is high, `pred_sel` shows the predicate register of the lowest-numbered valid entry that matches `op_dst`. Entry 0 has the highest priority.
- R7: If both sources have a length above 1 and the two lengths differ, the operation raises the exception.
- R8: If any source with a length above 1 has a length different from `len_dst`, the operation raises the exception. This covers a source longer than the vector destination, a shorter one, and a vector source with a scalar destination.
- R9: A jump (`op_is_jump = 1`) whose target register `op_src1` has a length above 1 raises the exception.
- R10: If any length is 0 or above `MAXVL`, or if any operand's `base + length` exceeds `NREG`, the operation raises the exception.
- R11: `op_valid` is ignored while `busy` is 1. The running operation's lane outputs and pass count are unchanged, and no exception is raised.
- R12: A rejected operation sets `exc` for exactly one cycle, the cycle after acceptance. `busy` stays 0, and no lane issues or writes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation presented |
| op_is_jump | input | 1 | Operation is a jump whose target is op_src1 |
| op_dst | input | REG_W | Destination base register |
| op_src1 | input | REG_W | First source base register |
| op_src2 | input | REG_W | Second source base register |
| len_dst | input | LEN_W | Destination vector length |
| len_src1 | input | LEN_W | First source vector length |
| len_src2 | input | LEN_W | Second source vector length |
| bind_valid | input | NBIND | Valid bit per binding entry |
| bind_dst | input | NBIND*REG_W | Destination register per entry, entry i at bits i*REG_W |
| bind_pred | input | NBIND*REG_W | Predicate register per entry, entry i at bits i*REG_W |
| pred_sel | output | REG_W | Predicate register to read for op_dst |
| pred_value | input | MAXVL | Low MAXVL bits of the register named by pred_sel |
| busy | output | 1 | Passes in progress |
| exc | output | 1 | One-cycle exception pulse |
| lane_issue | output | LANES | Element issued on lane |
| lane_wen | output | LANES | Writeback enable on lane |
| lane_dst | output | LANES*REG_W | Destination register per lane |
| lane_src1 | output | LANES*REG_W | First source register per lane |
| lane_src2 | output | LANES*REG_W | Second source register per lane |

## Verification
The hardest case to reach from the ports is an operation arriving while a long vector is still in flight. The stimulus starts a 16-element, four-pass operation. It then holds `op_valid` high with an illegal operand shape for every remaining pass, and drops it only in the last busy cycle. The bench then confirms three things: the running pass sequence and its register numbers are undisturbed, the exception never fires, and the next idle cycle is clean. Partial final passes are also covered: a 5-element vector is run over four lanes with a sparse predicate, which shows both the idle lanes and masked elements that are walked without being written.

// File: rtl/pred_seq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the predicated element sequencer.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package pred_seq_pkg;

    // Sequencer control state.
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Ceiling division used to size the pass counter.
    function automatic int unsigned div_ceil(input int unsigned a, input int unsigned b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/pred_bind_lookup.sv
`timescale 1ns/1ps
// Looks up the predicate register bound to a destination register.
// The lowest-numbered valid matching entry wins.
// Assumes: entries are packed at i*REG_W in the flat vectors.
module pred_bind_lookup #(
    parameter int NBIND = 4,
    parameter int REG_W = 5
) (
    input  logic [NBIND-1:0]       bind_valid,
    input  logic [NBIND*REG_W-1:0] bind_dst,
    input  logic [NBIND*REG_W-1:0] bind_pred,
    input  logic [REG_W-1:0]       dst_reg,
    output logic                   hit,
    output logic [REG_W-1:0]       pred_reg
);

    // Priority search: walk from the highest index down so entry 0 ends on top.
    always_comb begin
        hit      = 1'b0;
        pred_reg = '0;
        for (int i = NBIND - 1; i >= 0; i--) begin
            if (bind_valid[i] && (bind_dst[i*REG_W +: REG_W] == dst_reg)) begin
                hit      = 1'b1;
                pred_reg = bind_pred[i*REG_W +: REG_W];
            end
        end
    end

endmodule

// File: rtl/op_shape_check.sv
`timescale 1ns/1ps
// Decides whether an operation's operand shapes are legal.
// Assumes: length 1 means scalar, and element e uses register base+e.
module op_shape_check #(
    parameter int NREG  = 32,
    parameter int MAXVL = 16,
    parameter int REG_W = 5,
    parameter int LEN_W = 5
) (
    input  logic             is_jump,
    input  logic [REG_W-1:0] dst_reg,
    input  logic [REG_W-1:0] src1_reg,
    input  logic [REG_W-1:0] src2_reg,
    input  logic [LEN_W-1:0] dst_len,
    input  logic [LEN_W-1:0] src1_len,
    input  logic [LEN_W-1:0] src2_len,
    output logic             bad,
    output logic [LEN_W-1:0] vl
);

    logic s1_vec, s2_vec;
    logic len_bad, range_bad, src_mismatch, dst_mismatch, jump_vec;

    // Classify each source as scalar or vector.
    always_comb begin
        s1_vec = src1_len > LEN_W'(1);
        s2_vec = src2_len > LEN_W'(1);
    end

    // Length limits and register file bounds.
    always_comb begin
        len_bad   = (dst_len == '0) || (src1_len == '0) || (src2_len == '0) ||
                    (int'(dst_len) > MAXVL) || (int'(src1_len) > MAXVL) ||
                    (int'(src2_len) > MAXVL);
        range_bad = (int'(dst_reg)  + int'(dst_len)  > NREG) ||
                    (int'(src1_reg) + int'(src1_len) > NREG) ||
                    (int'(src2_reg) + int'(src2_len) > NREG);
    end

    // Shape agreement between operands, and the vector jump target rule.
    always_comb begin
        src_mismatch = s1_vec && s2_vec && (src1_len != src2_len);
        dst_mismatch = (s1_vec && (src1_len != dst_len)) ||
                       (s2_vec && (src2_len != dst_len));
        jump_vec     = is_jump && s1_vec;
    end

    // Combined verdict; the element count follows the destination.
    always_comb begin
        bad = len_bad || range_bad || src_mismatch || dst_mismatch || jump_vec;
        vl  = dst_len;
    end

endmodule

// File: rtl/lane_issue_unit.sv
`timescale 1ns/1ps
// One issue lane: maps the current pass to this lane's element and
// produces its register numbers and gated write enable.
// Assumes: range checks were done at acceptance, so register sums never wrap.
module lane_issue_unit #(
    parameter int LANE_ID = 0,
    parameter int LANES   = 4,
    parameter int MAXVL   = 16,
    parameter int REG_W   = 5,
    parameter int LEN_W   = 5,
    parameter int PASS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [PASS_W-1:0] pass,
    input  logic [LEN_W-1:0]  vl,
    input  logic [REG_W-1:0]  dst_base,
    input  logic [REG_W-1:0]  src1_base,
    input  logic [REG_W-1:0]  src2_base,
    input  logic              src1_vec,
    input  logic              src2_vec,
    input  logic [MAXVL-1:0]  mask,
    output logic              issue,
    output logic              wen,
    output logic [REG_W-1:0]  dst,
    output logic [REG_W-1:0]  src1,
    output logic [REG_W-1:0]  src2
);

    localparam int IDX_W = (MAXVL > 1) ? $clog2(MAXVL) : 1;

    int elem;

    // Element number carried by this lane in the current pass.
    always_comb elem = int'(pass) * LANES + LANE_ID;

    // Issue, gating and register numbers for the element.
    always_comb begin
        issue = busy && (elem < int'(vl));
        wen   = issue && mask[IDX_W'(elem)];
        dst   = dst_base + REG_W'(elem);
        src1  = src1_vec ? (src1_base + REG_W'(elem)) : src1_base;
        src2  = src2_vec ? (src2_base + REG_W'(elem)) : src2_base;
    end

    // R2: across consecutive passes of one operation the destination steps by LANES.
    p_dst_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && issue) |-> (dst == $past(dst) + REG_W'(LANES)));

    // R3: a scalar source keeps the same register across passes.
    p_scalar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !src2_vec) |-> $stable(src2));

endmodule

// File: rtl/pred_elem_sequencer.sv
`timescale 1ns/1ps
// Top of the predicated element sequencer. It accepts one operation when
// idle, checks its shape, captures the destination's predicate and walks
// the elements over ceil(VL/LANES) passes, one pass per cycle.
// Assumes: pred_value holds the register named by pred_sel in the same
// cycle, and MAXVL does not exceed the predicate register width.
module pred_elem_sequencer
    import pred_seq_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int MAXVL = 16,
    parameter int LANES = 4,
    parameter int NBIND = 4,
    parameter int REG_W = $clog2(NREG),
    parameter int LEN_W = $clog2(MAXVL + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic                   op_is_jump,
    input  logic [REG_W-1:0]       op_dst,
    input  logic [REG_W-1:0]       op_src1,
    input  logic [REG_W-1:0]       op_src2,
    input  logic [LEN_W-1:0]       len_dst,
    input  logic [LEN_W-1:0]       len_src1,
    input  logic [LEN_W-1:0]       len_src2,
    input  logic [NBIND-1:0]       bind_valid,
    input  logic [NBIND*REG_W-1:0] bind_dst,
    input  logic [NBIND*REG_W-1:0] bind_pred,
    output logic [REG_W-1:0]       pred_sel,
    input  logic [MAXVL-1:0]       pred_value,
    output logic                   busy,
    output logic                   exc,
    output logic [LANES-1:0]       lane_issue,
    output logic [LANES-1:0]       lane_wen,
    output logic [LANES*REG_W-1:0] lane_dst,
    output logic [LANES*REG_W-1:0] lane_src1,
    output logic [LANES*REG_W-1:0] lane_src2
);

    localparam int NPASS  = int'(div_ceil(MAXVL, LANES));
    localparam int PASS_W = (NPASS > 1) ? $clog2(NPASS) : 1;

    seq_state_e        state_q;
    logic [PASS_W-1:0] pass_q, last_q;
    logic [LEN_W-1:0]  vl_q;
    logic [REG_W-1:0]  dst_q, src1_q, src2_q;
    logic              src1_vec_q, src2_vec_q;
    logic [MAXVL-1:0]  mask_q;
    logic              exc_q;

    logic              pred_hit;
    logic              chk_bad;
    logic [LEN_W-1:0]  chk_vl;
    logic              accept;

    // Predicate binding lookup for the presented destination.
    pred_bind_lookup #(
        .NBIND (NBIND),
        .REG_W (REG_W)
    ) u_bind (
        .bind_valid (bind_valid),
        .bind_dst   (bind_dst),
        .bind_pred  (bind_pred),
        .dst_reg    (op_dst),
        .hit        (pred_hit),
        .pred_reg   (pred_sel)
    );

    // Operand shape legality.
    op_shape_check #(
        .NREG  (NREG),
        .MAXVL (MAXVL),
        .REG_W (REG_W),
        .LEN_W (LEN_W)
    ) u_check (
        .is_jump  (op_is_jump),
        .dst_reg  (op_dst),
        .src1_reg (op_src1),
        .src2_reg (op_src2),
        .dst_len  (len_dst),
        .src1_len (len_src1),
        .src2_len (len_src2),
        .bad      (chk_bad),
        .vl       (chk_vl)
    );

    // New operations are taken only while idle.
    always_comb accept = op_valid && (state_q == SEQ_IDLE);

    // Sequencer state, operand capture and pass counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            pass_q     <= '0;
            last_q     <= '0;
            vl_q       <= '0;
            dst_q      <= '0;
            src1_q     <= '0;
            src2_q     <= '0;
            src1_vec_q <= 1'b0;
            src2_vec_q <= 1'b0;
            mask_q     <= '0;
            exc_q      <= 1'b0;
        end else begin
            exc_q <= accept && chk_bad;
            if (accept && !chk_bad) begin
                state_q    <= SEQ_RUN;
                pass_q     <= '0;
                last_q     <= PASS_W'((int'(chk_vl) - 1) / LANES);
                vl_q       <= chk_vl;
                dst_q      <= op_dst;
                src1_q     <= op_src1;
                src2_q     <= op_src2;
                src1_vec_q <= len_src1 > LEN_W'(1);
                src2_vec_q <= len_src2 > LEN_W'(1);
                mask_q     <= pred_hit ? pred_value : '1;
            end else if (state_q == SEQ_RUN) begin
                if (pass_q == last_q) begin
                    state_q <= SEQ_IDLE;
                end else begin
                    pass_q <= pass_q + PASS_W'(1);
                end
            end
        end
    end

    // Status outputs.
    always_comb begin
        busy = (state_q == SEQ_RUN);
        exc  = exc_q;
    end

    // One issue lane per physical lane; LANES = 1 gives the sequential form.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_issue_unit #(
            .LANE_ID (g),
            .LANES   (LANES),
            .MAXVL   (MAXVL),
            .REG_W   (REG_W),
            .LEN_W   (LEN_W),
            .PASS_W  (PASS_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .busy      (busy),
            .pass      (pass_q),
            .vl        (vl_q),
            .dst_base  (dst_q),
            .src1_base (src1_q),
            .src2_base (src2_q),
            .src1_vec  (src1_vec_q),
            .src2_vec  (src2_vec_q),
            .mask      (mask_q),
            .issue     (lane_issue[g]),
            .wen       (lane_wen[g]),
            .dst       (lane_dst[g*REG_W +: REG_W]),
            .src1      (lane_src1[g*REG_W +: REG_W]),
            .src2      (lane_src2[g*REG_W +: REG_W])
        );
    end

    // R1: a legal accepted operation starts its first pass in the next cycle.
    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !chk_bad) |=> (busy && pass_q == '0));

    // R12: a rejected operation never starts.
    p_reject_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && chk_bad) |=> !busy);

    // R12: the exception appears only while idle and only after a presented operation.
    p_exc_origin_r12: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> (!busy && $past(op_valid) && !$past(busy)));

    // R11: a request while busy never raises the exception.
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid) |=> !exc);

    // R4: the captured predicate holds for the whole operation.
    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mask_q));

    // R2: nothing issues or writes back while idle.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lane_issue == '0 && lane_wen == '0));

    // R1: the pass counter never runs past the final pass.
    p_pass_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pass_q <= last_q));

endmodule

// File: tb/tb_pred_elem_sequencer.sv
`timescale 1ns/1ps
module tb_pred_elem_sequencer;

    localparam int LANES = 4;
    localparam int REG_W = 5;
    localparam int NROWS = 15;

    // Row: dst, src1, src2, len_dst, len_src1, len_src2 (5 bits each), jump, expected exception
    localparam logic [31:0] TBL [0:NROWS-1] = '{
        {5'd8,  5'd0,  5'd16, 5'd8,  5'd8,  5'd8,  1'b0, 1'b0},
        {5'd4,  5'd10, 5'd1,  5'd16, 5'd16, 5'd1,  1'b0, 1'b0},
        {5'd20, 5'd0,  5'd2,  5'd5,  5'd1,  5'd5,  1'b0, 1'b0},
        {5'd12, 5'd12, 5'd12, 5'd1,  5'd1,  5'd1,  1'b0, 1'b0},
        {5'd24, 5'd1,  5'd2,  5'd8,  5'd1,  5'd1,  1'b0, 1'b0},
        {5'd16, 5'd0,  5'd0,  5'd16, 5'd1,  5'd1,  1'b0, 1'b0},
        {5'd3,  5'd8,  5'd0,  5'd1,  5'd1,  5'd1,  1'b1, 1'b0},
        {5'd8,  5'd0,  5'd16, 5'd4,  5'd4,  5'd3,  1'b0, 1'b1},
        {5'd8,  5'd0,  5'd16, 5'd4,  5'd6,  5'd1,  1'b0, 1'b1},
        {5'd5,  5'd0,  5'd1,  5'd1,  5'd4,  5'd1,  1'b0, 1'b1},
        {5'd8,  5'd0,  5'd16, 5'd8,  5'd4,  5'd1,  1'b0, 1'b1},
        {5'd3,  5'd8,  5'd0,  5'd4,  5'd4,  5'd1,  1'b1, 1'b1},
        {5'd28, 5'd0,  5'd0,  5'd8,  5'd1,  5'd1,  1'b0, 1'b1},
        {5'd8,  5'd0,  5'd0,  5'd0,  5'd1,  5'd1,  1'b0, 1'b1},
        {5'd8,  5'd0,  5'd0,  5'd17, 5'd1,  5'd1,  1'b0, 1'b1}
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   op_valid = 1'b0;
    logic                   op_is_jump = 1'b0;
    logic [REG_W-1:0]       op_dst = '0, op_src1 = '0, op_src2 = '0;
    logic [4:0]             len_dst = 5'd1, len_src1 = 5'd1, len_src2 = 5'd1;
    logic [3:0]             bind_valid;
    logic [4*REG_W-1:0]     bind_dst, bind_pred;
    logic [REG_W-1:0]       pred_sel;
    logic [15:0]            pred_value;
    logic                   busy, exc;
    logic [LANES-1:0]       lane_issue, lane_wen;
    logic [LANES*REG_W-1:0] lane_dst, lane_src1, lane_src2;
    logic [31:0]            pregs [0:31];

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    pred_elem_sequencer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_is_jump (op_is_jump),
        .op_dst     (op_dst),
        .op_src1    (op_src1),
        .op_src2    (op_src2),
        .len_dst    (len_dst),
        .len_src1   (len_src1),
        .len_src2   (len_src2),
        .bind_valid (bind_valid),
        .bind_dst   (bind_dst),
        .bind_pred  (bind_pred),
        .pred_sel   (pred_sel),
        .pred_value (pred_value),
        .busy       (busy),
        .exc        (exc),
        .lane_issue (lane_issue),
        .lane_wen   (lane_wen),
        .lane_dst   (lane_dst),
        .lane_src1  (lane_src1),
        .lane_src2  (lane_src2)
    );

    always #2.5 clk = ~clk;

    // Register file model answering predicate reads.
    always_comb pred_value = pregs[pred_sel][15:0];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected binding: first valid entry matching the destination.
    task automatic bind_model(input logic [4:0] d, output bit hit, output logic [4:0] pr);
        hit = 1'b0;
        pr  = '0;
        for (int i = 0; i < 4; i++) begin
            if (!hit && bind_valid[i] && bind_dst[i*5 +: 5] == d) begin
                hit = 1'b1;
                pr  = bind_pred[i*5 +: 5];
            end
        end
    endtask

    // Check one pass of lane outputs against the model.
    task automatic check_pass(input int p, input int d, input int s1, input int s2,
                              input int dl, input int s1l, input int s2l,
                              input bit hit, input logic [31:0] pv);
        logic [3:0] e_iss, e_wen;
        logic [19:0] e_dst, e_s1, e_s2;
        bit dst_ok, src_ok;
        e_iss = '0; e_wen = '0; e_dst = '0; e_s1 = '0; e_s2 = '0;
        dst_ok = 1'b1; src_ok = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            int e;
            e = p * LANES + l;
            if (e < dl) begin
                e_iss[l] = 1'b1;
                e_wen[l] = hit ? pv[e] : 1'b1;
                e_dst[l*5 +: 5] = 5'(d + e);
                e_s1[l*5 +: 5]  = 5'((s1l > 1) ? s1 + e : s1);
                e_s2[l*5 +: 5]  = 5'((s2l > 1) ? s2 + e : s2);
                if (lane_dst[l*5 +: 5] != e_dst[l*5 +: 5]) dst_ok = 1'b0;
                if (lane_src1[l*5 +: 5] != e_s1[l*5 +: 5] ||
                    lane_src2[l*5 +: 5] != e_s2[l*5 +: 5]) src_ok = 1'b0;
            end
        end
        chk(busy == 1'b1, "R1", "busy during pass", 64'(busy), 64'd1);
        chk(lane_issue == e_iss, "R2", "lane issue", 64'(lane_issue), 64'(e_iss));
        chk(dst_ok, "R2", "lane dst", 64'(lane_dst), 64'(e_dst));
        chk(src_ok, "R3", "lane src", {12'd0, lane_src1, lane_src2}, {12'd0, e_s1, e_s2});
        if (hit) chk(lane_wen == e_wen, "R4", "predicated wen", 64'(lane_wen), 64'(e_wen));
        else     chk(lane_wen == e_wen, "R5", "unbound wen", 64'(lane_wen), 64'(e_wen));
        chk(exc == 1'b0, "R12", "no exception while running", 64'(exc), 64'd0);
    endtask

    function automatic string exc_tag(input int dl, input int s1l, input int s2l, input bit j);
        if (j && s1l > 1) return "R9";
        if (dl == 0 || dl > 16) return "R10";
        if (s1l > 1 && s2l > 1 && s1l != s2l) return "R7";
        if ((s1l > 1 && s1l != dl) || (s2l > 1 && s2l != dl)) return "R8";
        return "R10";
    endfunction

    // Apply one table row; called and returns at a falling edge.
    task automatic run_row(input logic [31:0] r);
        int d, s1, s2, dl, s1l, s2l, np;
        bit j, eexc, hit;
        logic [4:0] pr;
        logic [31:0] pv;
        d = int'(r[31:27]); s1 = int'(r[26:22]); s2 = int'(r[21:17]);
        dl = int'(r[16:12]); s1l = int'(r[11:7]); s2l = int'(r[6:2]);
        j = r[1]; eexc = r[0];
        op_dst = 5'(d); op_src1 = 5'(s1); op_src2 = 5'(s2);
        len_dst = 5'(dl); len_src1 = 5'(s1l); len_src2 = 5'(s2l);
        op_is_jump = j;
        op_valid = 1'b1;
        bind_model(5'(d), hit, pr);
        pv = pregs[pr];
        #1;
        if (hit) chk(pred_sel == pr, "R6", "pred_sel", 64'(pred_sel), 64'(pr));
        @(negedge clk);
        op_valid = 1'b0;
        if (eexc) begin
            chk(exc == 1'b1, exc_tag(dl, s1l, s2l, j), "exception raised", 64'(exc), 64'd1);
            chk(busy == 1'b0 && lane_wen == '0, "R12", "rejected op idle",
                {busy, 4'(lane_wen)}, 64'd0);
            @(negedge clk);
            chk(exc == 1'b0, "R12", "exception one cycle", 64'(exc), 64'd0);
        end else begin
            np = (dl + LANES - 1) / LANES;
            for (int p = 0; p < np; p++) begin
                check_pass(p, d, s1, s2, dl, s1l, s2l, hit, pv);
                @(negedge clk);
            end
            chk(busy == 1'b0 && lane_issue == '0, "R1", "done after passes",
                {busy, 4'(lane_issue)}, 64'd0);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #500000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) pregs[i] = 32'hFFFF_FFFF;
        pregs[3] = 32'h0000_A5C3;
        pregs[5] = 32'h0000_0000;
        pregs[6] = 32'h0000_0000;
        pregs[7] = 32'h0000_0F0A;
        // entry0: 8->3, entry1 (invalid): 4->5, entry2: 8->6, entry3: 20->7
        bind_valid = 4'b1101;
        bind_dst   = {5'd20, 5'd8, 5'd4, 5'd8};
        bind_pred  = {5'd7,  5'd6, 5'd5, 5'd3};

        // Reset state (R1, R12)
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
        chk(exc == 1'b0, "R12", "exc after reset", 64'(exc), 64'd0);
        chk(lane_issue == '0 && lane_wen == '0, "R2", "lanes after reset",
            {lane_issue, lane_wen}, 64'd0);

        // Table walk
        for (int k = 0; k < NROWS; k++) run_row(TBL[k]);

        // R11: requests held high during a four-pass operation are ignored.
        op_dst = 5'd4; op_src1 = 5'd10; op_src2 = 5'd1;
        len_dst = 5'd16; len_src1 = 5'd16; len_src2 = 5'd1; op_is_jump = 1'b0;
        op_valid = 1'b1;
        @(negedge clk);
        op_dst = 5'd8; op_src1 = 5'd0; op_src2 = 5'd16;
        len_dst = 5'd4; len_src1 = 5'd4; len_src2 = 5'd3;
        for (int p = 0; p < 4; p++) begin
            chk(busy == 1'b1 && exc == 1'b0, "R11", "busy, no exc while held",
                {busy, exc}, 64'd2);
            chk(lane_dst[4:0] == 5'(4 + p * 4), "R11", "running op undisturbed",
                64'(lane_dst[4:0]), 64'(4 + p * 4));
            if (p == 3) op_valid = 1'b0;
            @(negedge clk);
        end
        chk(busy == 1'b0 && exc == 1'b0, "R11", "clean end after held request",
            {busy, exc}, 64'd0);

        // R6 + R4: a bound destination with an all-zero predicate never writes back.
        pregs[3] = 32'h0000_0000;
        run_row({5'd8, 5'd0, 5'd16, 5'd8, 5'd8, 5'd8, 1'b0, 1'b0});

        // R1: back-to-back legal operations, each one cycle long.
        run_row({5'd12, 5'd12, 5'd12, 5'd1, 5'd1, 5'd1, 1'b0, 1'b0});
        run_row({5'd0, 5'd0, 5'd0, 5'd4, 5'd4, 5'd4, 1'b0, 1'b0});

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule